// File: doc/BRIEF.md
# Conventional Backfill and Paged Expanded-Memory Decoder

This block sits behind the bus interface of a 16-bit memory expansion card that carries two separate DRAM regions: system RAM and expanded-memory RAM. On every memory cycle it decides whether the card answers. If it does, it also says which RAM region is addressed and gives the on-board physical address. Conventional memory below 640K is topped up in 128K steps, one step per switch input. For example, setting the three highest switches brings a 256K host up to 640K. Addresses from 1MB up to the top of system RAM map linearly when the extended-memory input is set.

A 64K expanded-memory window is made of four 16K slots. Each slot is mapped on its own to any of the 512 16K pages of expanded RAM. The boot driver places the window at any 16K boundary below 8MB. It writes the base and the slot mappings through I/O registers, and no switch is involved. After reset the window and every slot are closed, so only the backfill switches, the extended-memory input and the I/O registers have any effect. Wherever the window is placed, an open slot takes priority over system-RAM decode.

The decode is registered. A memory cycle presented with `mem_strobe` in one clock gives its result in the next clock, marked by `dec_vld`. The bus cannot be stalled, so there is no back-pressure: each strobed cycle produces exactly one result. Register writes that land at a clock edge apply to memory cycles sampled at later edges.

Top module: `bfems_decoder`

## Requirements
- R1: After reset all outputs are low. The window is closed and every slot is disabled, so an address inside the reset window position (base 0) is not decoded as expanded memory, even after a slot register has been written with its enable set.
- R2: A conventional address (A23..A20 = 0) with region index A19..A17 = k, for k below the switch count, selects system RAM when switch bit k is set, with phys_addr equal to A22..A0. With bit k clear, that region is not answered.
- R3: Conventional addresses from 640K to 1MB (A19..A17 = 5, 6 or 7) never select system RAM.
- R4: The window register sits at I/O offset 4 from the base port 0x0260. Data bit 9 opens the window, and bits 8..0 give the window base in 16K units, matching A22..A14. Slot registers sit at offsets 0 to 3, with bits 8..0 holding the page number and bit 9 holding the enable. The slot index is the address's 16K unit minus the base, taken only when that difference is 0 to 3, with no wrap. Requires A23 = 0. For an enabled slot, the result is expanded RAM with phys_addr equal to {page, A13..A0}.
- R5: An address in a disabled slot, or in any slot while the window is closed, is not decoded by the window. System decode (R2, R7) then applies to it.
- R6: An enabled window slot takes priority over system decode, in both backfilled and extended areas.
- R7: With ext_mem_en set, addresses from 1MB up to 8MB minus 1 select system RAM with phys_addr equal to A22..A0. With ext_mem_en clear, that range is not answered. Addresses at or above 8MB are never answered.
- R8: Each strobed cycle gives one result, with dec_vld high, in the following clock. A clock without a strobe gives dec_vld, board_sel, sel_sys and sel_ems all low in the following clock. sel_sys and sel_ems are never high together. board_sel is high exactly when one of them is. phys_addr is 0 when the card does not answer.
- R9: I/O writes to ports other than base+0 to base+4 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 24 | Bus memory address A23..A0 |
| mem_strobe | input | 1 | A memory cycle is presented this clock |
| io_wr | input | 1 | I/O write strobe |
| io_addr | input | 16 | I/O port address |
| io_wdata | input | 10 | I/O write data (register bits 9..0) |
| backfill_sw | input | 5 | One enable per 128K conventional region, bit k = region k |
| ext_mem_en | input | 1 | Enables linear system RAM from 1MB |
| dec_vld | output | 1 | Result of the previous clock's strobed cycle |
| board_sel | output | 1 | The card answers the cycle |
| sel_sys | output | 1 | System RAM region selected |
| sel_ems | output | 1 | Expanded RAM region selected |
| phys_addr | output | 23 | On-board physical address |

## Verification
The tests use several switch settings: none, the upper three and all five. The addresses probed sit on both sides of each 128K region edge and across the 640K to 1MB hole, which separates correct region indexing from an off-by-one or a missing 640K limit. The window is probed at its first and last bytes, just outside both ends and in a disabled slot. It is placed in the upper memory area, over a backfilled region, in extended memory and at the very top of its range. Those placements separate priority errors, slot-index errors and wraparound from correct mapping. Page numbers of all zeros, all ones and alternating bits reveal concatenation mistakes. Writes to nearby and aliased ports, each followed by a probe, show whether register decode is incomplete.

// File: rtl/bfems_pkg.sv
package bfems_pkg;
  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_SYS  = 2'd1,
    RGN_EMS  = 2'd2
  } rgn_e;

  localparam int PAGE_AW = 14;
endpackage

// File: rtl/bfems_regs.sv
module bfems_regs #(
  parameter int IO_AW     = 16,
  parameter int IO_BASE   = 16'h0260,
  parameter int NUM_PAGES = 4,
  parameter int PB        = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          io_wr,
  input  logic [IO_AW-1:0] io_addr,
  input  logic [PB:0]   io_wdata,
  output logic          page_en  [NUM_PAGES],
  output logic [PB-1:0] page_num [NUM_PAGES],
  output logic          win_en,
  output logic [PB-1:0] win_base
);
  localparam logic [IO_AW-1:0] CTRL_PORT = IO_AW'(IO_BASE + NUM_PAGES);

  for (genvar g = 0; g < NUM_PAGES; g++) begin : g_slot
    localparam logic [IO_AW-1:0] SLOT_PORT = IO_AW'(IO_BASE + g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        page_en[g]  <= 1'b0;
        page_num[g] <= '0;
      end else if (io_wr && io_addr == SLOT_PORT) begin
        page_en[g]  <= io_wdata[PB];
        page_num[g] <= io_wdata[PB-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_en   <= 1'b0;
      win_base <= '0;
    end else if (io_wr && io_addr == CTRL_PORT) begin
      win_en   <= io_wdata[PB];
      win_base <= io_wdata[PB-1:0];
    end
  end
endmodule

// File: rtl/bfems_window.sv
module bfems_window
  import bfems_pkg::*;
#(
  parameter int BUS_AW    = 24,
  parameter int NUM_PAGES = 4,
  parameter int PB        = 9
) (
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              page_en  [NUM_PAGES],
  input  logic [PB-1:0]     page_num [NUM_PAGES],
  input  logic              win_en,
  input  logic [PB-1:0]     win_base,
  output logic              hit,
  output logic [PB+PAGE_AW-1:0] phys
);
  localparam int IDX_W = $clog2(NUM_PAGES);
  localparam int UW    = PB + 1;
  localparam int TOP   = PB + PAGE_AW;

  logic [UW-1:0]    diff;
  logic [IDX_W-1:0] slot;
  logic             low, in_win;

  always_comb begin
    low    = (bus_addr[BUS_AW-1:TOP] == '0);
    diff   = {1'b0, bus_addr[TOP-1:PAGE_AW]} - {1'b0, win_base};
    slot   = diff[IDX_W-1:0];
    in_win = win_en && low && (diff < UW'(NUM_PAGES));
    hit    = in_win && page_en[slot];
    phys   = {page_num[slot], bus_addr[PAGE_AW-1:0]};
  end
endmodule

// File: rtl/bfems_sysmap.sv
module bfems_sysmap #(
  parameter int BUS_AW  = 24,
  parameter int SYS_AW  = 23,
  parameter int CONV_AW = 20,
  parameter int RGN_AW  = 17,
  parameter int NUM_SW  = 5
) (
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [NUM_SW-1:0] backfill_sw,
  input  logic              ext_mem_en,
  output logic              hit,
  output logic [SYS_AW-1:0] phys
);
  localparam int RIDX_W = CONV_AW - RGN_AW;

  logic [(2**RIDX_W)-1:0] sw_pad;
  logic [RIDX_W-1:0]      ridx;
  logic                   conv, bf_hit, ext_hit;

  always_comb begin
    sw_pad             = '0;
    sw_pad[NUM_SW-1:0] = backfill_sw;
    conv    = (bus_addr[BUS_AW-1:CONV_AW] == '0);
    ridx    = bus_addr[CONV_AW-1:RGN_AW];
    bf_hit  = conv && sw_pad[ridx];
    ext_hit = ext_mem_en && !conv && (bus_addr[BUS_AW-1:SYS_AW] == '0);
    hit     = bf_hit || ext_hit;
    phys    = bus_addr[SYS_AW-1:0];
  end
endmodule

// File: rtl/bfems_decoder.sv
module bfems_decoder
  import bfems_pkg::*;
#(
  parameter int BUS_AW    = 24,
  parameter int SYS_AW    = 23,
  parameter int EMS_AW    = 23,
  parameter int CONV_AW   = 20,
  parameter int RGN_AW    = 17,
  parameter int NUM_SW    = 5,
  parameter int NUM_PAGES = 4,
  parameter int IO_AW     = 16,
  parameter int IO_BASE   = 16'h0260
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [BUS_AW-1:0]     bus_addr,
  input  logic                  mem_strobe,
  input  logic                  io_wr,
  input  logic [IO_AW-1:0]      io_addr,
  input  logic [EMS_AW-14:0]    io_wdata,
  input  logic [NUM_SW-1:0]     backfill_sw,
  input  logic                  ext_mem_en,
  output logic                  dec_vld,
  output logic                  board_sel,
  output logic                  sel_sys,
  output logic                  sel_ems,
  output logic [((SYS_AW > EMS_AW) ? SYS_AW : EMS_AW)-1:0] phys_addr
);
  localparam int PB      = EMS_AW - PAGE_AW;
  localparam int PHYS_AW = (SYS_AW > EMS_AW) ? SYS_AW : EMS_AW;

  logic          page_en  [NUM_PAGES];
  logic [PB-1:0] page_num [NUM_PAGES];
  logic          win_en;
  logic [PB-1:0] win_base;
  logic          ems_hit, sys_hit;
  logic [EMS_AW-1:0] ems_phys;
  logic [SYS_AW-1:0] sys_phys;

  rgn_e               nxt_rgn, rgn_q;
  logic [PHYS_AW-1:0] nxt_phys, phys_q;
  logic               vld_q;

  bfems_regs #(
    .IO_AW(IO_AW), .IO_BASE(IO_BASE), .NUM_PAGES(NUM_PAGES), .PB(PB)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
    .io_wdata(io_wdata), .page_en(page_en), .page_num(page_num),
    .win_en(win_en), .win_base(win_base)
  );

  bfems_window #(
    .BUS_AW(BUS_AW), .NUM_PAGES(NUM_PAGES), .PB(PB)
  ) u_window (
    .bus_addr(bus_addr), .page_en(page_en), .page_num(page_num),
    .win_en(win_en), .win_base(win_base), .hit(ems_hit), .phys(ems_phys)
  );

  bfems_sysmap #(
    .BUS_AW(BUS_AW), .SYS_AW(SYS_AW), .CONV_AW(CONV_AW),
    .RGN_AW(RGN_AW), .NUM_SW(NUM_SW)
  ) u_sysmap (
    .bus_addr(bus_addr), .backfill_sw(backfill_sw), .ext_mem_en(ext_mem_en),
    .hit(sys_hit), .phys(sys_phys)
  );

  // Window first, then system RAM; an unanswered cycle reports address 0.
  always_comb begin
    nxt_rgn  = RGN_NONE;
    nxt_phys = '0;
    if (mem_strobe) begin
      if (ems_hit) begin
        nxt_rgn  = RGN_EMS;
        nxt_phys = PHYS_AW'(ems_phys);
      end else if (sys_hit) begin
        nxt_rgn  = RGN_SYS;
        nxt_phys = PHYS_AW'(sys_phys);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rgn_q  <= RGN_NONE;
      phys_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      rgn_q  <= nxt_rgn;
      phys_q <= nxt_phys;
      vld_q  <= mem_strobe;
    end
  end

  assign dec_vld   = vld_q;
  assign sel_sys   = (rgn_q == RGN_SYS);
  assign sel_ems   = (rgn_q == RGN_EMS);
  assign board_sel = (rgn_q != RGN_NONE);
  assign phys_addr = phys_q;
endmodule

// File: rtl/bfems_decoder_chk.sv
module bfems_decoder_chk #(
  parameter int BUS_AW  = 24,
  parameter int SYS_AW  = 23,
  parameter int CONV_AW = 20,
  parameter int RGN_AW  = 17,
  parameter int NUM_SW  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [BUS_AW-1:0] bus_addr,
  input logic              mem_strobe,
  input logic [NUM_SW-1:0] backfill_sw,
  input logic              dec_vld,
  input logic              board_sel,
  input logic              sel_sys,
  input logic              sel_ems
);
  localparam int RIDX_W = CONV_AW - RGN_AW;

  logic [(2**RIDX_W)-1:0] sw_pad;
  logic [RIDX_W-1:0]      ridx;
  logic                   conv, hole, above;

  always_comb begin
    sw_pad             = '0;
    sw_pad[NUM_SW-1:0] = backfill_sw;
    ridx  = bus_addr[CONV_AW-1:RGN_AW];
    conv  = (bus_addr[BUS_AW-1:CONV_AW] == '0);
    hole  = conv && (32'(ridx) >= NUM_SW);
    above = (bus_addr[BUS_AW-1:SYS_AW] != '0);
  end

  // R8
  one_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel_sys && sel_ems));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_strobe |=> (!dec_vld && !board_sel));

  // R8
  result_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_strobe |=> dec_vld);

  // R2
  backfill_answers_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_strobe && conv && sw_pad[ridx]) |=> board_sel);

  // R3
  hole_no_sys_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_strobe && hole) |=> !sel_sys);

  // R7
  above_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_strobe && above) |=> !board_sel);
endmodule

bind bfems_decoder bfems_decoder_chk #(
  .BUS_AW(BUS_AW), .SYS_AW(SYS_AW), .CONV_AW(CONV_AW),
  .RGN_AW(RGN_AW), .NUM_SW(NUM_SW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .mem_strobe(mem_strobe),
  .backfill_sw(backfill_sw), .dec_vld(dec_vld), .board_sel(board_sel),
  .sel_sys(sel_sys), .sel_ems(sel_ems)
);

// File: tb/bfems_decoder_tb_top.sv
`timescale 1ns/1ps
module bfems_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] bus_addr = '0;
  logic        mem_strobe = 1'b0;
  logic        io_wr = 1'b0;
  logic [15:0] io_addr = '0;
  logic [9:0]  io_wdata = '0;
  logic [4:0]  backfill_sw = '0;
  logic        ext_mem_en = 1'b0;
  logic        dec_vld, board_sel, sel_sys, sel_ems;
  logic [22:0] phys_addr;

  typedef struct {
    logic        sys;
    logic        ems;
    logic [22:0] phys;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;

  localparam logic [15:0] BASE = 16'h0260;
  localparam logic [9:0]  EN   = 10'h200;

  always #4 clk = ~clk;

  bfems_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .mem_strobe(mem_strobe),
    .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata),
    .backfill_sw(backfill_sw), .ext_mem_en(ext_mem_en),
    .dec_vld(dec_vld), .board_sel(board_sel), .sel_sys(sel_sys),
    .sel_ems(sel_ems), .phys_addr(phys_addr)
  );

  task automatic probe(input logic [23:0] a, input logic s, input logic e,
                       input logic [22:0] p, input string tag);
    exp_t x;
    x.sys = s; x.ems = e; x.phys = p; x.tag = tag;
    exp_q.push_back(x);
    bus_addr   = a;
    mem_strobe = 1'b1;
    @(negedge clk);
    mem_strobe = 1'b0;
  endtask

  task automatic io_write(input logic [15:0] port, input logic [9:0] d);
    io_addr  = port;
    io_wdata = d;
    io_wr    = 1'b1;
    @(negedge clk);
    io_wr    = 1'b0;
  endtask

  // Monitor: one expected item per result
  always @(negedge clk) begin
    if (rst_n && dec_vld) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R8 unexpected result: actual sys=%0b ems=%0b expected none queued",
                 sel_sys, sel_ems);
      end else begin
        exp_t x;
        x = exp_q.pop_front();
        if (sel_sys !== x.sys || sel_ems !== x.ems || phys_addr !== x.phys ||
            board_sel !== (x.sys | x.ems)) begin
          errors++;
          $display("FAIL %s: actual sys=%0b ems=%0b sel=%0b phys=%h expected sys=%0b ems=%0b phys=%h",
                   x.tag, sel_sys, sel_ems, board_sel, phys_addr, x.sys, x.ems, x.phys);
        end
      end
    end
  end

  task automatic idle_check(input string tag);
    @(negedge clk);
    checks++;
    if (dec_vld !== 1'b0 || board_sel !== 1'b0 || sel_sys !== 1'b0 || sel_ems !== 1'b0) begin
      errors++;
      $display("FAIL %s idle: actual vld=%0b sel=%0b sys=%0b ems=%0b expected all 0",
               tag, dec_vld, board_sel, sel_sys, sel_ems);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (dec_vld !== 1'b0 || board_sel !== 1'b0 || sel_sys !== 1'b0 ||
        sel_ems !== 1'b0 || phys_addr !== '0) begin
      errors++;
      $display("FAIL R1 reset outputs: actual vld=%0b sel=%0b phys=%h expected 0",
               dec_vld, board_sel, phys_addr);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R1
    probe(24'h000000, 0, 0, 23'h0, "R1 no switch");
    io_write(BASE + 16'd0, EN | 10'h000);
    probe(24'h000000, 0, 0, 23'h0, "R1 window closed after reset");
    probe(24'h00C000, 0, 0, 23'h0, "R1 window closed slot3");

    // R2
    backfill_sw = 5'b11100;
    probe(24'h040000, 1, 0, 23'h040000, "R2 region2 start");
    probe(24'h09FFFF, 1, 0, 23'h09FFFF, "R2 region4 end");
    probe(24'h03FFFF, 0, 0, 23'h0, "R2 region1 off");
    probe(24'h000000, 0, 0, 23'h0, "R2 region0 off");
    idle_check("R8");

    // R3
    backfill_sw = 5'b11111;
    probe(24'h000000, 1, 0, 23'h000000, "R2 region0 on");
    probe(24'h0A0000, 0, 0, 23'h0, "R3 640K");
    probe(24'h0FFFFF, 0, 0, 23'h0, "R3 top of 1MB");

    // R4
    io_write(BASE + 16'd0, EN | 10'h000);
    io_write(BASE + 16'd1, EN | 10'h1FF);
    io_write(BASE + 16'd2, EN | 10'h055);
    io_write(BASE + 16'd3, 10'h000);
    io_write(BASE + 16'd4, EN | 10'h034);
    probe(24'h0D0000, 0, 1, 23'h000000, "R4 slot0 first byte");
    probe(24'h0D7FFF, 0, 1, 23'h7FFFFF, "R4 slot1 all ones");
    probe(24'h0D8123, 0, 1, 23'h154123, "R4 slot2 pattern");
    probe(24'h0DC000, 0, 0, 23'h0, "R5 slot3 disabled");
    probe(24'h0E0000, 0, 0, 23'h0, "R4 past window");
    probe(24'h0CFFFF, 0, 0, 23'h0, "R4 before window");

    // R6
    io_write(BASE + 16'd4, EN | 10'h010);
    probe(24'h040010, 0, 1, 23'h000010, "R6 window over backfill");
    probe(24'h047FFF, 0, 1, 23'h7FFFFF, "R6 slot1 over backfill");
    probe(24'h04C010, 1, 0, 23'h04C010, "R5 disabled slot falls to backfill");
    probe(24'h050000, 1, 0, 23'h050000, "R4 after window backfill");
    io_write(BASE + 16'd0, EN | 10'h0AA);
    probe(24'h040010, 0, 1, 23'h2A8010, "R4 slot0 remapped");
    io_write(BASE + 16'd4, 10'h010);
    probe(24'h040010, 1, 0, 23'h040010, "R5 window closed");

    // R7
    probe(24'h100000, 0, 0, 23'h0, "R7 ext disabled");
    ext_mem_en = 1'b1;
    probe(24'h100000, 1, 0, 23'h100000, "R7 ext 1MB");
    probe(24'h7FFFFF, 1, 0, 23'h7FFFFF, "R7 ext top");
    probe(24'h800000, 0, 0, 23'h0, "R7 above RAM");
    probe(24'hFFFFFF, 0, 0, 23'h0, "R7 top of bus");
    io_write(BASE + 16'd4, EN | 10'h050);
    probe(24'h140000, 0, 1, 23'h2A8000, "R6 window over ext");
    probe(24'h14C000, 1, 0, 23'h14C000, "R5 disabled slot ext");

    // R4 no wrap
    io_write(BASE + 16'd4, EN | 10'h1FF);
    probe(24'h7FC000, 0, 1, 23'h2A8000, "R4 window at top");
    probe(24'h000000, 1, 0, 23'h000000, "R4 no wrap to 0");
    probe(24'h800000, 0, 0, 23'h0, "R4 no window above 8MB");

    // R9
    io_write(BASE + 16'd4, EN | 10'h010);
    io_write(BASE + 16'd5, 10'h000);
    io_write(16'h1264, 10'h000);
    io_write(16'h0270, EN | 10'h155);
    io_write(16'h0A60, EN | 10'h155);
    probe(24'h040010, 0, 1, 23'h2A8010, "R9 stray writes ignored");
    idle_check("R8");

    repeat (2) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R8 missing results: actual %0d pending expected 0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule